// File: doc/BRIEF.md
# Coherent Test Bit-Pattern Generator

This block produces repeating serial bit patterns that drive a delta-modulation decoder under test. It has no timing source of its own. Each bit is issued on a bit enable derived from the master clock, so the stimulus stays locked to the decoder's clock and the decoder settles into a repeating cycle that can be observed. The patterns are plain square waves, composites that splice two sub-patterns over fixed windows, a fixed 22-bit burst, and a silence mode that substitutes an idle pattern.

A composite turns a one-off transient into a steady cycle. Examples are step-size growth when dense transitions give way to long runs, and decay from a long run back to alternation. A start-of-cycle marker flags the first bit of every full period. The selection is sampled only at a period boundary, so a period is never cut short. The composite window lengths are parameters.

Top module: `cbpg_top`

## Requirements
- R1: One bit is issued for each clock in which `bit_en` is high. `dvalid` is high in the following clock and low otherwise. `dout` changes only in a clock where `dvalid` is high.
- R2: `mode` codes 0, 1 and 2 give square patterns that start with zero, with half-periods of 1, 2 and 4 bits (01, 0011, 00001111 repeated). Codes 3 and 4 give square patterns that start with one, with half-periods of 6 and 8 bits.
- R3: `mode` code 5 issues alternating bits starting with 0 for WIN_A bits, then 00001111 repeated for WIN_A bits. The period is 2*WIN_A bits.
- R4: `mode` code 6 issues alternating bits starting with 0 for WIN_B bits, then eight zeros and eight ones repeated for WIN_B bits.
- R5: `mode` code 7 issues WIN_C copies of `fill_one`, then alternating bits starting with 0 for WIN_C bits.
- R6: `mode` code 8 issues a 22-bit period of five zeros followed by seventeen alternating bits starting with 1.
- R7: With `silent` high, `mode` is ignored and an idle pattern is issued. `idle_sel` 0 or 3 gives 01 repeated, 1 gives 0011 repeated, and 2 gives the 8-bit period 01001101.
- R8: `sop` is high together with `dvalid` on the first bit of every period and low on all other bits.
- R9: Changes to `mode`, `silent`, `idle_sel` and `fill_one` take effect only on the first bit of the next period. Until then the current period finishes unchanged.
- R10: A synchronous `rst` clears `dout`, `dvalid` and `sop`. After `rst`, the first issued bit is bit zero of a new period for the configuration presented at that moment.
- R11: `mode` codes 9 to 15 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit enable derived from the master clock |
| mode | input | 4 | Pattern select |
| silent | input | 1 | Substitute the idle pattern |
| idle_sel | input | 2 | Idle pattern select |
| fill_one | input | 1 | Level of the run in mode 7 |
| dout | output | 1 | Serial stimulus bit |
| dvalid | output | 1 | A bit was issued |
| sop | output | 1 | First bit of a period |

## Verification
The bench builds the block with the default windows of 64, 256 and 256 bits. This puts the full 512-bit composite periods and the longest counter range within reach, along with the 16-bit run pattern in the second half of mode 6. Some phases thin `bit_en` to one clock in three, which shows that the output hold and the period counting follow the enable rather than the clock. Configurations are changed in the middle of periods, and a reset is applied inside a long composite period, to exercise the boundary rule and the restart at phase zero.

// File: rtl/cbpg_pkg.sv
package cbpg_pkg;
  typedef enum logic [3:0] {
    M_SQ1 = 4'd0, M_SQ2 = 4'd1, M_SQ4 = 4'd2, M_SQ6 = 4'd3, M_SQ8 = 4'd4,
    M_MIX_A = 4'd5, M_MIX_B = 4'd6, M_MIX_C = 4'd7, M_BURST22 = 4'd8
  } pat_mode_e;

  typedef struct packed {
    logic       silent;
    logic [1:0] idle_sel;
    logic [3:0] mode;
    logic       fill_one;
  } pat_cfg_t;

  localparam logic [7:0] IDLE8 = 8'hB2;
endpackage

// File: rtl/cbpg_period.sv
module cbpg_period
  import cbpg_pkg::*;
#(
  parameter int WIN_A = 64,
  parameter int WIN_B = 256,
  parameter int WIN_C = 256,
  parameter int PW    = 9
) (
  input  pat_cfg_t        cfg,
  output logic [PW-1:0]   last
);
  localparam logic [PW-1:0] LAST_A = PW'(2*WIN_A - 1);
  localparam logic [PW-1:0] LAST_B = PW'(2*WIN_B - 1);
  localparam logic [PW-1:0] LAST_C = PW'(2*WIN_C - 1);

  always_comb begin
    if (cfg.silent) begin
      case (cfg.idle_sel)
        2'd1:    last = PW'(3);
        2'd2:    last = PW'(7);
        default: last = PW'(1);
      endcase
    end else begin
      case (cfg.mode)
        M_SQ2:     last = PW'(3);
        M_SQ4:     last = PW'(7);
        M_SQ6:     last = PW'(11);
        M_SQ8:     last = PW'(15);
        M_MIX_A:   last = LAST_A;
        M_MIX_B:   last = LAST_B;
        M_MIX_C:   last = LAST_C;
        M_BURST22: last = PW'(21);
        default:   last = PW'(1);
      endcase
    end
  end
endmodule

// File: rtl/cbpg_bitfn.sv
module cbpg_bitfn
  import cbpg_pkg::*;
#(
  parameter int WIN_A = 64,
  parameter int WIN_B = 256,
  parameter int WIN_C = 256,
  parameter int PW    = 9
) (
  input  pat_cfg_t      cfg,
  input  logic [PW-1:0] pos,
  output logic          bit_o
);
  localparam logic [PW-1:0] WA = PW'(WIN_A);
  localparam logic [PW-1:0] WB = PW'(WIN_B);
  localparam logic [PW-1:0] WC = PW'(WIN_C);

  logic [PW-1:0] qa, qb, qc, qr;
  assign qa = pos - WA;
  assign qb = pos - WB;
  assign qc = pos - WC;
  assign qr = pos - PW'(5);

  always_comb begin
    if (cfg.silent) begin
      case (cfg.idle_sel)
        2'd1:    bit_o = pos[1];
        2'd2:    bit_o = IDLE8[pos[2:0]];
        default: bit_o = pos[0];
      endcase
    end else begin
      case (cfg.mode)
        M_SQ2:     bit_o = pos[1];
        M_SQ4:     bit_o = pos[2];
        M_SQ6:     bit_o = (pos < PW'(6));
        M_SQ8:     bit_o = (pos < PW'(8));
        M_MIX_A:   bit_o = (pos < WA) ? pos[0] : qa[2];
        M_MIX_B:   bit_o = (pos < WB) ? pos[0] : qb[3];
        M_MIX_C:   bit_o = (pos < WC) ? cfg.fill_one : qc[0];
        M_BURST22: bit_o = (pos < PW'(5)) ? 1'b0 : ~qr[0];
        default:   bit_o = pos[0];
      endcase
    end
  end
endmodule

// File: rtl/cbpg_phase.sv
module cbpg_phase
  import cbpg_pkg::*;
#(
  parameter int WIN_A = 64,
  parameter int WIN_B = 256,
  parameter int WIN_C = 256,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  pat_cfg_t      in_cfg,
  output pat_cfg_t      cur_cfg,
  output logic [PW-1:0] cur_pos,
  output logic          first
);
  pat_cfg_t      cfg_q;
  logic [PW-1:0] pos_q;
  logic          wrap_q;
  logic [PW-1:0] last;

  assign cur_cfg = wrap_q ? in_cfg : cfg_q;
  assign cur_pos = wrap_q ? '0 : pos_q;
  assign first   = wrap_q;

  cbpg_period #(.WIN_A(WIN_A), .WIN_B(WIN_B), .WIN_C(WIN_C), .PW(PW)) u_period (
    .cfg  (cur_cfg),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_q <= 1'b1;
      pos_q  <= '0;
      cfg_q  <= '0;
    end else if (bit_en) begin
      cfg_q  <= cur_cfg;
      pos_q  <= cur_pos + PW'(1);
      wrap_q <= (cur_pos == last);
    end
  end
endmodule

// File: rtl/cbpg_top.sv
module cbpg_top
  import cbpg_pkg::*;
#(
  parameter int WIN_A = 64,
  parameter int WIN_B = 256,
  parameter int WIN_C = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [3:0] mode,
  input  logic       silent,
  input  logic [1:0] idle_sel,
  input  logic       fill_one,
  output logic       dout,
  output logic       dvalid,
  output logic       sop
);
  localparam int WMAX = (WIN_A > WIN_B) ? ((WIN_A > WIN_C) ? WIN_A : WIN_C)
                                        : ((WIN_B > WIN_C) ? WIN_B : WIN_C);
  localparam int LONG = (2*WMAX > 22) ? 2*WMAX : 22;
  localparam int PW   = $clog2(LONG);

  pat_cfg_t      in_cfg, cur_cfg;
  logic [PW-1:0] cur_pos;
  logic          first, bit_next;

  assign in_cfg = '{silent: silent, idle_sel: idle_sel, mode: mode, fill_one: fill_one};

  cbpg_phase #(.WIN_A(WIN_A), .WIN_B(WIN_B), .WIN_C(WIN_C), .PW(PW)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .in_cfg  (in_cfg),
    .cur_cfg (cur_cfg),
    .cur_pos (cur_pos),
    .first   (first)
  );

  cbpg_bitfn #(.WIN_A(WIN_A), .WIN_B(WIN_B), .WIN_C(WIN_C), .PW(PW)) u_bitfn (
    .cfg   (cur_cfg),
    .pos   (cur_pos),
    .bit_o (bit_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= 1'b0;
      dvalid <= 1'b0;
      sop    <= 1'b0;
    end else begin
      dvalid <= bit_en;
      sop    <= bit_en & first;
      if (bit_en) dout <= bit_next;
    end
  end
endmodule

// File: rtl/cbpg_check.sv
module cbpg_check #(
  parameter int LONG = 512
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic dout,
  input logic dvalid,
  input logic sop
);
  logic        prev_rst = 1'b1;
  logic [15:0] run_cnt  = 16'd0;

  always @(posedge clk) begin
    prev_rst <= rst;
    if (rst) run_cnt <= 16'd0;
    else if (dvalid) run_cnt <= sop ? 16'd1 : ((run_cnt == 16'hFFFF) ? run_cnt : run_cnt + 16'd1);
  end

  AST_VALID_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> (dvalid == $past(bit_en))); // R1
  AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && !dvalid) |-> $stable(dout)); // R1
  AST_SOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    sop |-> dvalid); // R8
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= 16'(LONG)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!dvalid && !sop)); // R10
endmodule

bind cbpg_top cbpg_check #(.LONG(LONG)) u_check (
  .clk    (clk),
  .rst    (rst),
  .bit_en (bit_en),
  .dout   (dout),
  .dvalid (dvalid),
  .sop    (sop)
);

// File: tb/cbpg_top_test.sv
module cbpg_top_test;
  localparam int WA = 64, WB = 256, WC = 256;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0;
  logic [3:0] mode = 4'd0;
  logic silent = 1'b0, fill_one = 1'b0;
  logic [1:0] idle_sel = 2'd0;
  logic dout, dvalid, sop;

  int checks = 0, bad = 0, cyc = 0;
  bit thin = 0;
  int thin_cnt = 0;

  cbpg_top #(.WIN_A(WA), .WIN_B(WB), .WIN_C(WC)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode), .silent(silent),
    .idle_sel(idle_sel), .fill_one(fill_one), .dout(dout), .dvalid(dvalid), .sop(sop));

  always #5 clk = ~clk;

  bit q[$];
  bit e_dout = 0, e_valid = 0, e_sop = 0, started = 0, in_reset = 1;
  string tag = "R10";
  logic [7:0] l_cfg;

  task automatic push_run(bit v, int n);
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  task automatic push_alt(bit s, int n);
    for (int i = 0; i < n; i++) q.push_back(s ^ bit'(i % 2));
  endtask

  function automatic string mode_tag(logic s, logic [3:0] m);
    if (s) return "R7";
    case (m)
      0, 1, 2, 3, 4: return "R2";
      5: return "R3";
      6: return "R4";
      7: return "R5";
      8: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic refill();
    if (silent) begin
      case (idle_sel)
        2'd1: begin push_run(0, 2); push_run(1, 2); end
        2'd2: begin q.push_back(0); q.push_back(1); push_run(0, 2); push_run(1, 2);
                    q.push_back(0); q.push_back(1); end
        default: push_alt(0, 2);
      endcase
    end else begin
      case (mode)
        1: begin push_run(0, 2); push_run(1, 2); end
        2: begin push_run(0, 4); push_run(1, 4); end
        3: begin push_run(1, 6); push_run(0, 6); end
        4: begin push_run(1, 8); push_run(0, 8); end
        5: begin push_alt(0, WA); for (int k = 0; k < WA/8; k++) begin push_run(0, 4); push_run(1, 4); end end
        6: begin push_alt(0, WB); for (int k = 0; k < WB/16; k++) begin push_run(0, 8); push_run(1, 8); end end
        7: begin push_run(fill_one, WC); push_alt(0, WC); end
        8: begin push_run(0, 5); push_alt(1, 17); end
        default: push_alt(0, 2);
      endcase
    end
    l_cfg = {silent, idle_sel, mode, fill_one};
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      q.delete(); e_dout = 0; e_valid = 0; e_sop = 0; in_reset = 1; tag = "R10";
    end else if (bit_en) begin
      if (q.size() == 0) begin refill(); e_sop = 1; end else e_sop = 0;
      if ({silent, idle_sel, mode, fill_one} != l_cfg) tag = "R9";
      else if (in_reset) tag = "R10";
      else tag = mode_tag(l_cfg[7], l_cfg[4:1]);
      in_reset = 0;
      e_dout = q.pop_front();
      e_valid = 1;
    end else begin
      e_valid = 0; e_sop = 0;
    end
  end

  task automatic chk(string r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(in_reset ? "R10" : "R1", "dvalid", dvalid, e_valid);
      chk(in_reset ? "R10" : "R8", "sop", sop, e_sop);
      chk(tag, "dout", dout, e_dout);
    end
    if (thin) begin bit_en <= (thin_cnt % 3 == 0); thin_cnt++; end
    else bit_en <= !rst;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  initial begin
    run(4);
    rst = 0;                              // R10 reset state checked above
    for (int m = 0; m < 5; m++) begin mode = 4'(m); run(50); end   // R2
    thin = 1; mode = 4'd2; run(90); thin = 0;                       // R1 thinned enable
    mode = 4'd5; run(300);                                          // R3
    mode = 4'd6; run(1100);                                         // R4
    fill_one = 0; mode = 4'd7; run(1100);                           // R5
    fill_one = 1; run(1100);
    mode = 4'd8; run(600);                                          // R6, change mid-period R9
    mode = 4'd9; run(30); mode = 4'd15; run(30);                    // R11
    silent = 1; mode = 4'd6;
    for (int s = 0; s < 4; s++) begin idle_sel = 2'(s); run(40); end // R7
    silent = 0; mode = 4'd7; run(700);
    rst = 1; run(2); rst = 0; mode = 4'd3; run(60);                 // R10 mid-period reset
    thin = 1; mode = 4'd5; run(500); mode = 4'd8; run(400); thin = 0; // R9 with thinned enable
    run(20);
    summary();
  end
endmodule